// File: doc/BRIEF.md
# Triggered Event Capture Buffer

This block keeps a running history of 14-bit converter samples in a ring memory clocked by a fixed 100 MHz sample clock. When the trigger input goes high, it freezes one event window. The window holds a programmable number of samples from before the trigger, followed by the samples after it, up to a programmable power-of-two length. The block then plays the whole window out on a separate readout clock, oldest sample first, as one gap-free burst marked by a valid flag.

The readout clock may run at 100 MHz or slower and has no fixed phase relation to the sample clock. A four-phase request/acknowledge handshake, passed through two-flop synchronisers, joins the two clock domains. The output has no ready input, so back-pressure is not possible. Once a burst starts, the consumer must take one word on every readout clock in which valid is high. Configuration inputs must be held steady from the trigger until valid falls.

Top module: `evcap_top`

## Requirements
- R1: While armed, one sample is written on every sample-clock rising edge. The trigger passes two synchroniser flops, so the sample present at the third sample-clock rising edge after `trig_i` goes high is the first sample after the trigger.
- R2: The 3-bit `size_code_i` selects the event length as 16 << code for codes 0 to 6 (16, 32, 64, 128, 256, 512, 1024). Code 7 also gives 1024.
- R3: The event begins `pre_i` samples before the first post-trigger sample, so the first word read out is that sample minus `pre_i` positions.
- R4: A `pre_i` value equal to or larger than the event length is treated as the event length minus one.
- R5: Each event is read out as exactly one burst: `valid_o` rises once and stays high for a number of consecutive readout cycles equal to the event length.
- R6: Words in a burst come out in capture order with no sample skipped or repeated. With a sample source that counts up by one per sample clock, each word is the previous word plus one, modulo 2^14.
- R7: A trigger that arrives while an event is being captured or read out has no effect, and capture stops during that time. After `valid_o` has fallen, the block re-arms and a later trigger starts a new event.
- R8: An active-low `rst_n` forces `valid_o` low at once and clears all pointers and state. After reset is released, the block captures normally again.
- R9: Readout starts by itself after capture ends, on the readout clock, without any action from the consumer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp | input | 1 | Sample clock, 100 MHz |
| clk_rd | input | 1 | Readout clock, at most 100 MHz, independent of clk_smp |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| trig_i | input | 1 | Trigger request, level sensitive, asynchronous |
| smp_i | input | 14 | Sample word, taken on clk_smp |
| pre_i | input | 10 | Number of pre-trigger samples |
| size_code_i | input | 3 | Event length code |
| data_o | output | 14 | Event word, on clk_rd |
| valid_o | output | 1 | High while data_o carries event data |

## Verification
The bench builds the block with its default parameters: a 1024-entry ring, 14-bit samples, a 10-bit pre-trigger count and a top code of 6. It therefore covers every length code, including the full-ring 1024 window and the saturating code 7, and pre-trigger counts that wrap around the ring. The sample source is a counter, so each burst's first word and its continuity can be predicted from the trigger time alone. The readout clock runs at 14 ns against the 10 ns sample clock, which puts both synchroniser paths under genuinely asynchronous conditions.

// File: rtl/evcap_pkg.sv
package evcap_pkg;

  typedef enum logic [1:0] {W_ARM, W_CAP, W_HOLD, W_REL} wst_t;
  typedef enum logic [1:0] {R_IDLE, R_RUN, R_ACK} rst_t;

  // event length for a size code; codes above top_code saturate
  function automatic int unsigned ev_len(input int unsigned code,
                                         input int unsigned min_log,
                                         input int unsigned top_code);
    int unsigned k;
    k = (code > top_code) ? top_code : code;
    return 32'd1 << (min_log + k);
  endfunction

endpackage

// File: rtl/evcap_sync.sv
module evcap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/evcap_ram.sv
module evcap_ram #(
  parameter int DW = 14,
  parameter int AW = 10
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/evcap_wr.sv
module evcap_wr
  import evcap_pkg::*;
#(
  parameter int DW       = 14,
  parameter int AW       = 10,
  parameter int PW       = 10,
  parameter int CW       = 3,
  parameter int MIN_LOG  = 4,
  parameter int TOP_CODE = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_s,
  input  logic [DW-1:0] din,
  input  logic [PW-1:0] pre_i,
  input  logic [CW-1:0] code_i,
  input  logic          ack_s,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          req_o,
  output logic [AW-1:0] start_o,
  output logic [AW:0]   size_o
);
  localparam int SW = AW + 1;

  wst_t          st;
  logic [AW-1:0] wptr;
  logic [SW-1:0] rem, sz_n, pe_n, rem_n;

  always_comb begin
    sz_n  = SW'(ev_len(32'(code_i), MIN_LOG, TOP_CODE));
    pe_n  = (SW'(pre_i) >= sz_n) ? sz_n - SW'(1) : SW'(pre_i);
    rem_n = sz_n - pe_n - SW'(1);
  end

  assign wr_en   = (st == W_ARM) || (st == W_CAP);
  assign wr_addr = wptr;
  assign wr_data = din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= W_ARM;
      wptr    <= '0;
      rem     <= '0;
      req_o   <= 1'b0;
      start_o <= '0;
      size_o  <= '0;
    end else begin
      if (wr_en) wptr <= wptr + AW'(1);
      case (st)
        W_ARM: if (trig_s) begin
          start_o <= wptr - pe_n[AW-1:0];
          size_o  <= sz_n;
          rem     <= rem_n;
          if (rem_n == '0) begin
            st    <= W_HOLD;
            req_o <= 1'b1;
          end else begin
            st <= W_CAP;
          end
        end
        W_CAP: begin
          rem <= rem - SW'(1);
          if (rem == SW'(1)) begin
            st    <= W_HOLD;
            req_o <= 1'b1;
          end
        end
        W_HOLD: if (ack_s) begin
          req_o <= 1'b0;
          st    <= W_REL;
        end
        W_REL: if (!ack_s) st <= W_ARM;
        default: st <= W_ARM;
      endcase
    end
  end
endmodule

// File: rtl/evcap_rd.sv
module evcap_rd
  import evcap_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_r,
  input  logic [AW-1:0] start_i,
  input  logic [AW:0]   size_i,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          ack_o,
  output logic          valid_o
);
  localparam int SW = AW + 1;

  rst_t          st;
  logic [AW-1:0] raddr;
  logic [SW-1:0] left;

  assign rd_en   = (st == R_RUN);
  assign rd_addr = raddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= R_IDLE;
      raddr   <= '0;
      left    <= '0;
      ack_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= rd_en;  // memory read latency is one cycle
      case (st)
        R_IDLE: if (req_r) begin
          raddr <= start_i;
          left  <= size_i;
          st    <= R_RUN;
        end
        R_RUN: begin
          raddr <= raddr + AW'(1);
          left  <= left - SW'(1);
          if (left == SW'(1)) st <= R_ACK;
        end
        R_ACK: begin
          if (!ack_o) begin
            ack_o <= 1'b1;
          end else if (!req_r) begin
            ack_o <= 1'b0;
            st    <= R_IDLE;
          end
        end
        default: st <= R_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evcap_top.sv
module evcap_top #(
  parameter int DW       = 14,
  parameter int DEPTH    = 1024,
  parameter int PW       = 10,
  parameter int CW       = 3,
  parameter int MIN_LOG  = 4,
  parameter int TOP_CODE = 6
) (
  input  logic          clk_smp,
  input  logic          clk_rd,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic [DW-1:0] smp_i,
  input  logic [PW-1:0] pre_i,
  input  logic [CW-1:0] size_code_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o
);
  localparam int AW = $clog2(DEPTH);

  logic          trig_s, req_w, req_r, ack_r, ack_s;
  logic          wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr, start_w;
  logic [DW-1:0] wr_data;
  logic [AW:0]   size_w;

  evcap_sync #(.STAGES(2)) u_trig_sync (
    .clk(clk_smp), .rst_n(rst_n), .d_i(trig_i), .q_o(trig_s));
  evcap_sync #(.STAGES(2)) u_req_sync (
    .clk(clk_rd), .rst_n(rst_n), .d_i(req_w), .q_o(req_r));
  evcap_sync #(.STAGES(2)) u_ack_sync (
    .clk(clk_smp), .rst_n(rst_n), .d_i(ack_r), .q_o(ack_s));

  evcap_wr #(
    .DW(DW), .AW(AW), .PW(PW), .CW(CW), .MIN_LOG(MIN_LOG), .TOP_CODE(TOP_CODE)
  ) u_wr (
    .clk(clk_smp), .rst_n(rst_n), .trig_s(trig_s), .din(smp_i),
    .pre_i(pre_i), .code_i(size_code_i), .ack_s(ack_s),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_o(req_w), .start_o(start_w), .size_o(size_w));

  evcap_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(clk_smp), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .rclk(clk_rd), .re(rd_en), .raddr(rd_addr), .rdata(data_o));

  evcap_rd #(.AW(AW)) u_rd (
    .clk(clk_rd), .rst_n(rst_n), .req_r(req_r), .start_i(start_w),
    .size_i(size_w), .rd_en(rd_en), .rd_addr(rd_addr),
    .ack_o(ack_r), .valid_o(valid_o));
endmodule

// File: rtl/evcap_chk.sv
module evcap_chk #(
  parameter int AW = 10
) (
  input logic          clk_s,
  input logic          clk_r,
  input logic          rst_n,
  input logic          valid_o,
  input logic          req_r,
  input logic          req_w,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] start_w,
  input logic [AW:0]   size_w
);
  logic [AW:0] vcnt;

  always_ff @(posedge clk_r or negedge rst_n) begin
    if (!rst_n)       vcnt <= '0;
    else if (valid_o) vcnt <= vcnt + (AW+1)'(1);
    else              vcnt <= '0;
  end

  // R5: burst length equals the latched event length
  a_r5_burst_len: assert property (@(posedge clk_r) disable iff (!rst_n)
    $fell(valid_o) |-> (vcnt == size_w));

  // R9: readout only while the capture side holds its request
  a_r9_valid_needs_req: assert property (@(posedge clk_r) disable iff (!rst_n)
    valid_o |-> req_r);

  // R7: ring is frozen while an event is waiting or being read
  a_r7_frozen: assert property (@(posedge clk_s) disable iff (!rst_n)
    req_w |-> !wr_en);

  // R3: capture ends exactly one event length past the window start
  a_r3_window: assert property (@(posedge clk_s) disable iff (!rst_n)
    $rose(req_w) |-> (wr_addr == start_w + size_w[AW-1:0]));

  // R8: no valid output during reset
  always @(posedge clk_r) begin
    if (!rst_n) a_r8_reset_quiet: assert (!valid_o);
  end
endmodule

bind evcap_top evcap_chk #(.AW(AW)) u_chk (
  .clk_s(clk_smp), .clk_r(clk_rd), .rst_n(rst_n), .valid_o(valid_o),
  .req_r(req_r), .req_w(req_w), .wr_en(wr_en), .wr_addr(wr_addr),
  .start_w(start_w), .size_w(size_w));

// File: tb/sim_evcap_top.sv
`timescale 1ns/1ps
module sim_evcap_top;
  logic        clk_smp = 1'b0;
  logic        clk_rd  = 1'b0;
  logic        rst_n   = 1'b0;
  logic        trig_i  = 1'b0;
  logic [13:0] smp_i   = '0;
  logic [9:0]  pre_i   = '0;
  logic [2:0]  size_code_i = '0;
  logic [13:0] data_o;
  logic        valid_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_smp = ~clk_smp;
  always #7 clk_rd  = ~clk_rd;

  evcap_top u0 (
    .clk_smp(clk_smp), .clk_rd(clk_rd), .rst_n(rst_n), .trig_i(trig_i),
    .smp_i(smp_i), .pre_i(pre_i), .size_code_i(size_code_i),
    .data_o(data_o), .valid_o(valid_o));

  // counting sample source
  always @(negedge clk_smp) smp_i <= smp_i + 14'd1;

  // burst monitor on the readout side
  int          mcnt = 0, nrise = 0, gaps = 0;
  logic [13:0] first_w = '0, prev_w = '0;
  logic        prev_v = 1'b0;
  always @(negedge clk_rd) begin
    if (valid_o) begin
      if (!prev_v) nrise++;
      if (mcnt == 0) first_w = data_o;
      else if (data_o != prev_w + 14'd1) gaps++;
      prev_w = data_o;
      mcnt++;
    end
    prev_v = valid_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    mcnt = 0; nrise = 0; gaps = 0;
  endtask

  // fire a trigger; returns the sample present when trig rose
  task automatic fire(output logic [13:0] v);
    @(negedge clk_smp); #1;
    v = smp_i;
    trig_i = 1'b1;
    repeat (4) @(negedge clk_smp);
    trig_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk_smp);
      if (mcnt > 0 && !prev_v) break;
    end
    repeat (4) @(negedge clk_rd);
  endtask

  // {code, pre, expected length, expected effective pre}
  localparam logic [33:0] VEC [8] = '{
    {3'd0, 10'd5,    11'd16,   10'd5},
    {3'd0, 10'd40,   11'd16,   10'd15},
    {3'd1, 10'd0,    11'd32,   10'd0},
    {3'd2, 10'd63,   11'd64,   10'd63},
    {3'd3, 10'd127,  11'd128,  10'd127},
    {3'd4, 10'd600,  11'd256,  10'd255},
    {3'd6, 10'd1023, 11'd1024, 10'd1023},
    {3'd7, 10'd100,  11'd1024, 10'd100}
  };

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [13:0] v, exp_first;
    repeat (5) @(negedge clk_smp);
    chk(valid_o == 1'b0, "R8 reset valid", int'(valid_o), 0);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      size_code_i = VEC[i][33:31];
      pre_i       = VEC[i][30:21];
      repeat (1100) @(negedge clk_smp);
      clear_mon();
      fire(v);
      wait_done();
      exp_first = v + 14'd2 - {4'd0, VEC[i][9:0]};
      chk(mcnt == int'(VEC[i][20:10]), "R2 length", mcnt, int'(VEC[i][20:10]));
      chk(first_w == exp_first, "R1 R3 R4 first word", int'(first_w), int'(exp_first));
      chk(gaps == 0, "R6 contiguous", gaps, 0);
      chk(nrise == 1, "R5 R9 single burst", nrise, 1);
    end

    // R7: trigger during readout is ignored
    size_code_i = 3'd6; pre_i = 10'd10;
    repeat (1100) @(negedge clk_smp);
    clear_mon();
    fire(v);
    for (int i = 0; i < 5000 && !valid_o; i++) @(negedge clk_smp);
    fire(v);
    wait_done();
    repeat (1500) @(negedge clk_smp);
    chk(nrise == 1, "R7 ignored trigger bursts", nrise, 1);
    chk(mcnt == 1024, "R7 ignored trigger length", mcnt, 1024);

    // R7: re-armed after valid fell
    size_code_i = 3'd0; pre_i = 10'd3;
    repeat (1100) @(negedge clk_smp);
    clear_mon();
    fire(v);
    wait_done();
    exp_first = v + 14'd2 - 14'd3;
    chk(mcnt == 16, "R7 rearm length", mcnt, 16);
    chk(first_w == exp_first, "R7 rearm first word", int'(first_w), int'(exp_first));

    // R8: reset in the middle of a burst
    size_code_i = 3'd5; pre_i = 10'd0;
    repeat (1100) @(negedge clk_smp);
    clear_mon();
    fire(v);
    for (int i = 0; i < 5000 && mcnt < 20; i++) @(negedge clk_rd);
    rst_n = 1'b0;
    #1;
    chk(valid_o == 1'b0, "R8 mid-burst reset", int'(valid_o), 0);
    repeat (10) @(negedge clk_smp);
    rst_n = 1'b1;
    clear_mon();
    repeat (300) @(negedge clk_rd);
    chk(nrise == 0, "R8 quiet after reset", nrise, 0);

    // R8: normal capture after reset
    size_code_i = 3'd1; pre_i = 10'd7;
    repeat (1100) @(negedge clk_smp);
    clear_mon();
    fire(v);
    wait_done();
    exp_first = v + 14'd2 - 14'd7;
    chk(mcnt == 32, "R8 recovery length", mcnt, 32);
    chk(first_w == exp_first, "R8 recovery first word", int'(first_w), int'(exp_first));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule